// File: doc/BRIEF.md
# Complementary Bridge-Leg Driver with Dead Time and Break

This block takes one PWM reference and produces a pair of complementary pin signals for the high-side and low-side switches of a half bridge. Each rising transition on either leg is delayed by a programmable number of clock ticks. The leg that is switching off always releases first, so the two switches are never driven on together. Each pin has its own polarity bit and its own enable bit. A global arm bit gates both pins. While the block is disarmed, each pin holds a configured idle level, or both pins release their output enables when the high-impedance idle option is selected.

A break input with selectable active level overrides everything else. In the same cycle that it is seen, both pins fall back to their idle state. At the next clock edge the arm bit is cleared and a sticky break flag is set. The pins stay idle after the break is released, until control logic arms the block again.

Top module: `comp_pair_driver`

## Requirements
- R1: After reset, `arm_state` and `brk_flag` are 0 and both pins show their idle levels (`pad_hi`=`idle_hi`, `pad_lo`=`idle_lo`, each output enable = NOT `idle_hiz`).
- R2: With `dead_ticks`=0, armed, enabled and polarity 0, `pad_hi` equals `pwm_ref` as sampled at the previous clock edge and `pad_lo` is its inverse.
- R3: With `dead_ticks`=D, armed, enabled and polarity 0, a leg turns off at the first edge that samples the new reference level. The opposite leg turns on D edges later, so both pins are inactive for D cycles at every transition.
- R4: A reference level held for L edges gives max(L-D, 0) active cycles on the leg it drives. A pulse of L<=D produces no pulse on that leg.
- R5: `pad_hi` and `pad_lo` are never both at their active level. A pin is at its active level when its value differs from its polarity bit.
- R6: A polarity bit of 1 inverts its pin: the pin is 0 when active and 1 when inactive.
- R7: When armed, an output whose enable bit is 0 drives its inactive level, which equals its polarity bit.
- R8: While `arm_state` is 0, both pins show their idle levels, independent of `pwm_ref`.
- R9: The break is active when `brk_in` equals `brk_pol`. While it is active, both pins show their idle levels in the same cycle, with no clock edge in between.
- R10: An active break clears `arm_state` and sets `brk_flag` at the next edge. `arm_set` has no effect while the break is active. After release, the pins stay idle until `arm_set` is applied.
- R11: `brk_flag` stays set until `brk_flag_clr` is applied while no break is active. While a break is active, the break takes priority over the clear.
- R12: With `idle_hiz`=1, both output enables are 0 whenever the pins are idle. They are 1 whenever the block is armed and not in break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_ref | input | 1 | PWM reference |
| dead_ticks | input | DT_W | Dead time in clock ticks |
| hi_pol | input | 1 | High-side pin inverted when 1 |
| lo_pol | input | 1 | Low-side pin inverted when 1 |
| hi_en | input | 1 | High-side output enable bit |
| lo_en | input | 1 | Low-side output enable bit |
| arm_set | input | 1 | Pulse: set the arm bit |
| arm_clr | input | 1 | Pulse: clear the arm bit |
| idle_hi | input | 1 | High-side idle level |
| idle_lo | input | 1 | Low-side idle level |
| idle_hiz | input | 1 | Idle state releases both output enables |
| brk_in | input | 1 | Break input |
| brk_pol | input | 1 | Active level of the break input |
| brk_flag_clr | input | 1 | Pulse: clear the break flag |
| pad_hi | output | 1 | High-side pin value |
| pad_hi_oe | output | 1 | High-side pin output enable |
| pad_lo | output | 1 | Low-side pin value |
| pad_lo_oe | output | 1 | Low-side pin output enable |
| arm_state | output | 1 | Current arm bit |
| brk_flag | output | 1 | Sticky break flag |

## Verification
A break can arrive in the same cycle as a dead-time expiry that would turn a leg on. It can also arrive together with an `arm_set` or a `brk_flag_clr` pulse. The bench provokes these cases by asserting the break while the reference is toggling, and by pulsing `arm_set` and `brk_flag_clr` while the break is still held. It judges them by the pins being idle one delta after the break is applied, by the arm bit staying cleared, and by the flag staying set until the clear arrives after release.

// File: rtl/comp_pair_driver.sv
module comp_pair_driver #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_ref,
  input  logic [DT_W-1:0] dead_ticks,
  input  logic            hi_pol,
  input  logic            lo_pol,
  input  logic            hi_en,
  input  logic            lo_en,
  input  logic            arm_set,
  input  logic            arm_clr,
  input  logic            idle_hi,
  input  logic            idle_lo,
  input  logic            idle_hiz,
  input  logic            brk_in,
  input  logic            brk_pol,
  input  logic            brk_flag_clr,
  output logic            pad_hi,
  output logic            pad_hi_oe,
  output logic            pad_lo,
  output logic            pad_lo_oe,
  output logic            arm_state,
  output logic            brk_flag
);
  localparam logic [DT_W-1:0] AGE_MAX = {DT_W{1'b1}};

  logic            ref_q;
  logic [DT_W-1:0] age;
  logic [DT_W-1:0] age_nx;
  logic            dt_hi;
  logic            dt_lo;
  logic            arm;
  logic            flag;
  logic            brk_act;
  logic            settled;
  logic            live;

  assign brk_act = (brk_in == brk_pol);
  assign age_nx  = (pwm_ref != ref_q) ? '0 : ((age == AGE_MAX) ? age : age + 1'b1);
  assign settled = (age_nx >= dead_ticks);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      age   <= '0;
      dt_hi <= 1'b0;
      dt_lo <= 1'b0;
    end else begin
      ref_q <= pwm_ref;
      age   <= age_nx;
      dt_hi <= pwm_ref & settled;
      dt_lo <= ~pwm_ref & settled;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (brk_act)      arm <= 1'b0;
      else if (arm_set) arm <= 1'b1;
      else if (arm_clr) arm <= 1'b0;
      if (brk_act)           flag <= 1'b1;
      else if (brk_flag_clr) flag <= 1'b0;
    end
  end

  assign live      = arm & ~brk_act;
  assign pad_hi    = live ? ((hi_en & dt_hi) ^ hi_pol) : idle_hi;
  assign pad_lo    = live ? ((lo_en & dt_lo) ^ lo_pol) : idle_lo;
  assign pad_hi_oe = live | ~idle_hiz;
  assign pad_lo_oe = live | ~idle_hiz;
  assign arm_state = arm;
  assign brk_flag  = flag;
endmodule

module comp_pair_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_ref,
  input logic hi_pol,
  input logic lo_pol,
  input logic hi_en,
  input logic idle_hi,
  input logic idle_lo,
  input logic idle_hiz,
  input logic brk_in,
  input logic brk_pol,
  input logic brk_flag_clr,
  input logic pad_hi,
  input logic pad_hi_oe,
  input logic pad_lo,
  input logic pad_lo_oe,
  input logic arm_state,
  input logic brk_flag
);
  logic up;
  always_ff @(posedge clk) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  logic brk_on, hi_act, lo_act, hi_live;
  assign brk_on  = (brk_in == brk_pol);
  assign hi_act  = pad_hi ^ hi_pol;
  assign lo_act  = pad_lo ^ lo_pol;
  assign hi_live = arm_state & ~brk_on & hi_en;

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_state && !brk_on) |-> !(hi_act && lo_act));

  a_r9_break_idle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> (pad_hi == idle_hi && pad_lo == idle_lo &&
                pad_hi_oe == !idle_hiz && pad_lo_oe == !idle_hiz));

  a_r8_disarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_state |-> (pad_hi == idle_hi && pad_lo == idle_lo));

  a_r10_arm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |=> !arm_state);

  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |=> brk_flag);

  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_flag_clr) |=> brk_flag);

  a_r3_rise_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (up && hi_live && $past(hi_live) && $stable(hi_pol) && hi_act && !$past(hi_act))
      |-> $past(pwm_ref));

  a_r12_live_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_state && !brk_on) |-> (pad_hi_oe && pad_lo_oe));
endmodule

bind comp_pair_driver comp_pair_driver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .hi_pol(hi_pol), .lo_pol(lo_pol),
  .hi_en(hi_en), .idle_hi(idle_hi), .idle_lo(idle_lo), .idle_hiz(idle_hiz),
  .brk_in(brk_in), .brk_pol(brk_pol), .brk_flag_clr(brk_flag_clr),
  .pad_hi(pad_hi), .pad_hi_oe(pad_hi_oe), .pad_lo(pad_lo), .pad_lo_oe(pad_lo_oe),
  .arm_state(arm_state), .brk_flag(brk_flag)
);

// File: tb/tb_comp_pair_driver.sv
`timescale 1ns/1ps
module tb_comp_pair_driver;
  localparam int DT_W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_ref = 1'b0;
  logic [DT_W-1:0] dead_ticks = '0;
  logic hi_pol = 1'b0, lo_pol = 1'b0, hi_en = 1'b1, lo_en = 1'b1;
  logic arm_set = 1'b0, arm_clr = 1'b0;
  logic idle_hi = 1'b1, idle_lo = 1'b0, idle_hiz = 1'b0;
  logic brk_in = 1'b0, brk_pol = 1'b1, brk_flag_clr = 1'b0;
  logic pad_hi, pad_hi_oe, pad_lo, pad_lo_oe, arm_state, brk_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  comp_pair_driver #(.DT_W(DT_W)) dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic arm_now();
    arm_set = 1'b1; step(); arm_set = 1'b0;
  endtask

  task automatic t_reset();
    check(arm_state == 0 && brk_flag == 0, "R1 arm/flag", {arm_state, brk_flag}, 0);
    check(pad_hi == 1 && pad_lo == 0 && pad_hi_oe && pad_lo_oe, "R1 idle pins",
          {pad_hi, pad_lo, pad_hi_oe, pad_lo_oe}, 4'b1011);
    pwm_ref = 1'b1; step(2);
    check(pad_hi == 1 && pad_lo == 0, "R8 disarmed ignores ref", {pad_hi, pad_lo}, 2'b10);
    pwm_ref = 1'b0; step(2);
  endtask

  task automatic t_zero_dead();
    dead_ticks = 0; arm_now(); step(2);
    check(pad_hi == 0 && pad_lo == 1, "R2 low ref", {pad_hi, pad_lo}, 2'b01);
    pwm_ref = 1'b1; step();
    check(pad_hi == 1 && pad_lo == 0, "R2 high ref one edge", {pad_hi, pad_lo}, 2'b10);
    pwm_ref = 1'b0; step();
    check(pad_hi == 0 && pad_lo == 1, "R2 fall one edge", {pad_hi, pad_lo}, 2'b01);
  endtask

  task automatic t_dead_gap();
    int gap;
    dead_ticks = 3; step(5);
    pwm_ref = 1'b1; gap = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      check(!(pad_hi && pad_lo), "R5 exclusive", {pad_hi, pad_lo}, 0);
      if (!pad_hi && !pad_lo && pad_hi == 0) gap += (pad_hi == 0 && i < 6) ? 1 : 0;
      if (pad_hi) break;
    end
    check(gap == 3 && pad_hi == 1, "R3 rise gap", gap, 3);
    pwm_ref = 1'b0; step();
    check(pad_hi == 0 && pad_lo == 0, "R3 off first", {pad_hi, pad_lo}, 0);
    step(2);
    check(pad_lo == 0, "R3 still dead", pad_lo, 0);
    step();
    check(pad_lo == 1, "R3 low on after D", pad_lo, 1);
  endtask

  task automatic t_short_pulse();
    int cnt;
    dead_ticks = 3; step(4);
    pwm_ref = 1'b1; cnt = 0;
    for (int i = 0; i < 3; i++) begin step(); cnt += pad_hi; end
    pwm_ref = 1'b0;
    for (int i = 0; i < 5; i++) begin step(); cnt += pad_hi; end
    check(cnt == 0, "R4 pulse L=D suppressed", cnt, 0);
    step(3);
    pwm_ref = 1'b1; cnt = 0;
    for (int i = 0; i < 5; i++) begin step(); cnt += pad_hi; end
    pwm_ref = 1'b0;
    for (int i = 0; i < 5; i++) begin step(); cnt += pad_hi; end
    check(cnt == 2, "R4 pulse L=5 D=3", cnt, 2);
  endtask

  task automatic t_pol_en();
    dead_ticks = 0; pwm_ref = 1'b1; hi_pol = 1'b1; step(2);
    check(pad_hi == 0 && pad_lo == 0, "R6 inverted active", {pad_hi, pad_lo}, 0);
    pwm_ref = 1'b0; step();
    check(pad_hi == 1 && pad_lo == 1, "R6 inverted inactive", {pad_hi, pad_lo}, 2'b11);
    lo_en = 1'b0; lo_pol = 1'b1; step();
    check(pad_lo == 1, "R7 disabled at pol level", pad_lo, 1);
    lo_pol = 1'b0; step();
    check(pad_lo == 0, "R7 disabled inactive", pad_lo, 0);
    hi_pol = 1'b0; lo_en = 1'b1; step();
  endtask

  task automatic t_break();
    dead_ticks = 2; brk_pol = 1'b1;
    for (int i = 0; i < 6; i++) begin pwm_ref = ~pwm_ref; step(); end
    pwm_ref = 1'b1; step(2);
    brk_in = 1'b1; #1;
    check(pad_hi == 1 && pad_lo == 0, "R9 same-cycle idle", {pad_hi, pad_lo}, 2'b10);
    step();
    check(arm_state == 0 && brk_flag == 1, "R10 arm cleared flag set", {arm_state, brk_flag}, 2'b01);
    arm_set = 1'b1; brk_flag_clr = 1'b1; step(); arm_set = 1'b0; brk_flag_clr = 1'b0;
    check(arm_state == 0, "R10 arm_set ignored in break", arm_state, 0);
    check(brk_flag == 1, "R11 break beats clear", brk_flag, 1);
    brk_in = 1'b0; step(2);
    check(pad_hi == 1 && pad_lo == 0 && arm_state == 0, "R10 idle after release",
          {pad_hi, pad_lo, arm_state}, 3'b100);
    check(brk_flag == 1, "R11 flag sticky", brk_flag, 1);
    brk_flag_clr = 1'b1; step(); brk_flag_clr = 1'b0;
    check(brk_flag == 0, "R11 flag cleared", brk_flag, 0);
    arm_now(); step(3);
    check(arm_state == 1 && pad_hi == 0 + pwm_ref, "R10 rearm", {arm_state, pad_hi}, 2'b11);
    brk_pol = 1'b0; #1;
    check(pad_hi == 1 && pad_lo == 0, "R9 low-active break", {pad_hi, pad_lo}, 2'b10);
    step(); brk_pol = 1'b1; brk_flag_clr = 1'b1; step(); brk_flag_clr = 1'b0;
  endtask

  task automatic t_hiz();
    idle_hiz = 1'b1; step();
    check(pad_hi_oe == 0 && pad_lo_oe == 0, "R12 hiz idle", {pad_hi_oe, pad_lo_oe}, 0);
    arm_now();
    check(pad_hi_oe == 1 && pad_lo_oe == 1, "R12 armed drives", {pad_hi_oe, pad_lo_oe}, 2'b11);
    brk_in = 1'b1; #1;
    check(pad_hi_oe == 0 && pad_lo_oe == 0, "R12 break hiz", {pad_hi_oe, pad_lo_oe}, 0);
    step(); brk_in = 1'b0; step();
    arm_now(); arm_clr = 1'b1; step(); arm_clr = 1'b0;
    check(arm_state == 0 && pad_hi_oe == 0, "R8 arm_clr idles", {arm_state, pad_hi_oe}, 0);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step();
    t_reset();
    t_zero_dead();
    t_dead_gap();
    t_short_pulse();
    t_pol_en();
    t_break();
    t_hiz();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule